// File: doc/BRIEF.md
# Dual-Role SPI Serial Port

This block is a byte-wide synchronous serial port that works either as the clock-generating end of an SPI link or as the clock-following end. A 4-bit mode field chooses the role and, for the clock-generating role, the serial clock rate. Both roles share one 8-bit shift register, which sends its most significant bit first. Each time a byte is shifted out, the byte shifted in on the same clocks takes its place, so every transfer is full duplex. When a byte is complete it is copied into a receive holding register and a full flag is raised.

Software writes the shift register through a one-cycle write strobe and reads the holding register through a read strobe. In the clock-generating role a write starts an 8-bit transfer. In the following role a write preloads the byte that goes out on the next externally clocked transfer. The serial pins come with separate output enables, so the surrounding pad logic decides what is actually driven. Clearing the enable input holds the whole port in its reset state. The enable has to be cleared and set again to change the mode or the clock polarity.

Top module: `dual_role_spi`

## Requirements
- R1: While `cfg_en` is low, both output enables are low, and at the next clock `rx_full`, `wr_collide`, `rd_data` and `sdo_o` are all 0. Clearing `cfg_en` during a transfer abandons that transfer.
- R2: Mode values 0000, 0001, 0010, 0011 and 1010 select the master role. In this role `sck_oe` and `sdo_oe` are high, and when no transfer is running `sck_o` sits at the idle level given by `cfg_cpol`.
- R3: In the master role a write starts an 8-bit transfer, which is 16 SCK half-periods. A half-period lasts 2, 8 or 32 system clocks for modes 0000, 0001 and 0010, and `cfg_div`+1 clocks for mode 1010. In mode 0011 each half-period ends on a clock where `tmr_tick` is high.
- R4: Data is sent MSB first. `sdo_o` shows the current bit. SDI is sampled on the leading SCK edge (away from idle), and the shift register advances on the trailing edge (back to idle).
- R5: On the clock of the 8th trailing edge, the received byte appears on `rd_data` and `rx_full` rises. A `rd_en` pulse clears `rx_full`.
- R6: Modes 0100 and 0101 select the slave role. `sck_oe` is low, and the port shifts on edges of `sck_i` seen through a two-stage synchronizer. This requires `sck_i` to run at no more than a quarter of `clk`.
- R7: In mode 0100, a high `ss_n_i` (after synchronization) drops `sdo_oe`, clears the bit count and discards a partly received byte. A write made while deselected is accepted. Mode 0101 ignores `ss_n_i` and keeps `sdo_oe` high.
- R8: A write while a transfer is active (master busy, or slave with a byte partly shifted) is dropped and sets `wr_collide`. The flag stays set until `cfg_en` is cleared, and the transfer in progress is not affected.
- R9: All other mode values select no role. Nothing is driven, and a write starts no transfer.
- R10: If `rd_en` arrives on the same clock as a byte completes, `rx_full` is still set after that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Port enable; low holds the port in reset |
| cfg_mode | input | 4 | Role and clock-source selection |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_div | input | DIV_W | Half-period length minus one for mode 1010 |
| tmr_tick | input | 1 | External tick that paces SCK in mode 0011 |
| wr_en | input | 1 | Write strobe for the shift register |
| wr_data | input | DATA_W | Byte to send |
| rd_en | input | 1 | Read strobe; clears the full flag |
| rd_data | output | DATA_W | Last received byte |
| rx_full | output | 1 | A received byte is waiting |
| wr_collide | output | 1 | A write was dropped during a transfer |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the SDO pin |
| sck_i | input | 1 | Serial clock in (slave role) |
| sck_o | output | 1 | Serial clock out (master role) |
| sck_oe | output | 1 | Output enable for the SCK pin |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
Several properties are checked on every clock inside the RTL:
- each trailing edge shifts the register by exactly one place;
- a completed byte always raises the full flag, with the shifted value in the holding register;
- deselection always clears the bit position;
- the synchronizer stages follow one another;
- writes made during a transfer always leave the collision flag set;
- the port is quiet after the enable is cleared.

Other behaviour needs the bench's scenarios to show it. This covers the exact half-period length for each clock source, the bit order seen on the pins, the bytes received, and the outcome of a slave transfer that is aborted and then restarted. For the master role, a behavioural model in the bench predicts SCK, SDO, the flags and the read data on every clock.

// File: rtl/spi_port_pkg.sv
// Package: role type and mode constants shared by the dual-role SPI port.
// Assumes a 4-bit mode field; values that are not listed select no role.
package spi_port_pkg;

    typedef enum logic [1:0] {
        ROLE_OFF    = 2'd0,
        ROLE_MASTER = 2'd1,
        ROLE_SLAVE  = 2'd2
    } role_e;

    localparam logic [3:0] MODE_M_DIV4  = 4'b0000;
    localparam logic [3:0] MODE_M_DIV16 = 4'b0001;
    localparam logic [3:0] MODE_M_DIV64 = 4'b0010;
    localparam logic [3:0] MODE_M_TIMER = 4'b0011;
    localparam logic [3:0] MODE_M_PROG  = 4'b1010;
    localparam logic [3:0] MODE_S_SEL   = 4'b0100;
    localparam logic [3:0] MODE_S_FREE  = 4'b0101;

    // Maps a mode value to the role it selects.
    function automatic role_e role_of(input logic [3:0] mode);
        if (mode[3:2] == 2'b00 || mode == MODE_M_PROG) return ROLE_MASTER;
        if (mode[3:1] == 3'b010) return ROLE_SLAVE;
        return ROLE_OFF;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
// Module: multi-stage synchronizer for asynchronous serial pins.
// It also keeps a copy of the last synchronized value so that edges can be detected.
// Assumes the inputs change no faster than every two system clocks.
module spi_pin_sync #(
    parameter int              WIDTH   = 2,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] synced,
    output logic [WIDTH-1:0] prev
);

    logic [STAGES-1:0][WIDTH-1:0] chain;
    logic [WIDTH-1:0]             prev_q;

    // Moves each pin through the synchronizer stages and keeps the last output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain  <= {STAGES{RST_VAL}};
            prev_q <= RST_VAL;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
            prev_q <= chain[STAGES-1];
        end
    end

    assign synced = chain[STAGES-1];
    assign prev   = prev_q;

    generate
        if (STAGES >= 2) begin : g_chk
            // R6: the last stage always takes the value of the stage before it.
            assert_sync_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
                chain[STAGES-1] == $past(chain[STAGES-2]));
        end
    endgenerate

    // R6: the edge-detect copy lags the synchronized output by one clock.
    assert_sync_prev_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prev == $past(synced));

endmodule

// File: rtl/spi_baud_gen.sv
// Module: half-period tick generator for the master role.
// It counts system clocks while a transfer runs; in timer mode it passes the external tick through.
// Assumes the mode and divisor do not change while run is high.
module spi_baud_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [3:0]       mode,
    input  logic [DIV_W-1:0] div,
    input  logic             tmr_tick,
    output logic             tick
);
    import spi_port_pkg::*;

    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] half_len;
    logic [CNT_W-1:0] cnt_q;
    logic             use_timer;

    // Picks the length of one SCK half-period in system clocks.
    always_comb begin
        unique case (mode)
            MODE_M_DIV4:  half_len = CNT_W'(2);
            MODE_M_DIV16: half_len = CNT_W'(8);
            MODE_M_DIV64: half_len = CNT_W'(32);
            MODE_M_PROG:  half_len = {1'b0, div} + CNT_W'(1);
            default:      half_len = CNT_W'(1);
        endcase
    end

    assign use_timer = (mode == MODE_M_TIMER);
    assign tick      = run && (use_timer ? tmr_tick : (cnt_q == half_len - CNT_W'(1)));

    // Counts clocks within a half-period and wraps on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || use_timer) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R3: the counter never runs past the selected half-period.
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt_q < half_len);

endmodule

// File: rtl/spi_shift_core.sv
// Module: the shift engine shared by both roles.
// It holds the shift register, edge phase, bit count, receive buffer and flags.
// Assumes at most one edge event per clock and that role changes only while en is low.
module spi_shift_core #(
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  spi_port_pkg::role_e       role,
    input  logic                      ss_ok,
    input  logic                      tick,
    input  logic                      s_lead,
    input  logic                      s_trail,
    input  logic                      sdi,
    input  logic                      wr_en,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      rd_en,
    output logic                      sdo,
    output logic                      phase_o,
    output logic                      busy_o,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      rx_full,
    output logic                      wr_coll
);
    import spi_port_pkg::*;

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] shreg_q, rbuf_q, shifted;
    logic [CNT_W-1:0]  bitcnt_q;
    logic              phase_q, busy_q, samp_q, full_q, coll_q;
    logic              is_master, is_slave;
    logic              lead, trail, done, active, wr_ok, deselect;

    assign is_master = (role == ROLE_MASTER);
    assign is_slave  = (role == ROLE_SLAVE);
    assign deselect  = is_slave && !ss_ok;

    // Turns role-specific edge sources into common leading and trailing events.
    always_comb begin
        lead  = 1'b0;
        trail = 1'b0;
        if (is_master) begin
            lead  = tick && busy_q && !phase_q;
            trail = tick && busy_q && phase_q;
        end else if (is_slave) begin
            lead  = s_lead && ss_ok && !phase_q;
            trail = s_trail && ss_ok && phase_q;
        end
    end

    assign shifted = {shreg_q[DATA_W-2:0], samp_q};
    assign done    = trail && (bitcnt_q == LAST_BIT);
    assign active  = is_master ? busy_q : (phase_q || bitcnt_q != '0);
    assign wr_ok   = wr_en && (role != ROLE_OFF) && !active;

    // Runs the byte transfer: load, sample, shift, complete, and keep the flags.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            shreg_q  <= '0;
            rbuf_q   <= '0;
            bitcnt_q <= '0;
            phase_q  <= 1'b0;
            busy_q   <= 1'b0;
            samp_q   <= 1'b0;
            full_q   <= 1'b0;
            coll_q   <= 1'b0;
        end else begin
            if (rd_en) full_q <= 1'b0;
            if (wr_en && active) coll_q <= 1'b0 | 1'b1;
            if (wr_ok) begin
                shreg_q <= wr_data;
                if (is_master) begin
                    busy_q   <= 1'b1;
                    phase_q  <= 1'b0;
                    bitcnt_q <= '0;
                end
            end
            if (deselect) begin
                bitcnt_q <= '0;
                phase_q  <= 1'b0;
            end else if (lead) begin
                samp_q  <= sdi;
                phase_q <= 1'b1;
            end else if (trail) begin
                shreg_q <= shifted;
                phase_q <= 1'b0;
                if (done) begin
                    bitcnt_q <= '0;
                    rbuf_q   <= shifted;
                    full_q   <= 1'b1;
                    busy_q   <= 1'b0;
                end else begin
                    bitcnt_q <= bitcnt_q + CNT_W'(1);
                end
            end
        end
    end

    assign sdo     = shreg_q[DATA_W-1];
    assign phase_o = phase_q;
    assign busy_o  = busy_q;
    assign rd_data = rbuf_q;
    assign rx_full = full_q;
    assign wr_coll = coll_q;

    // R4: each trailing edge moves the register up by exactly one bit.
    assert_shift_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && trail) |=> shreg_q[DATA_W-1:1] == $past(shreg_q[DATA_W-2:0]));

    // R5: a completed byte raises the full flag and lands in the buffer.
    assert_done_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && done) |=> (full_q && rbuf_q == $past(shifted)));

    // R7: a deselected slave has no byte in progress after the clock.
    assert_deselect_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && deselect) |=> (bitcnt_q == '0 && !phase_q));

    // R8: a write during an active transfer leaves the collision flag set.
    assert_collide_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_en && active) |=> coll_q);

endmodule

// File: rtl/dual_role_spi.sv
// Module: top of the dual-role SPI port.
// It decodes the mode, synchronizes the slave-side pins, paces the master clock
// and drives the pin enables.
// Assumes cfg_mode and cfg_cpol change only while cfg_en is low.
module dual_role_spi #(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [3:0]        cfg_mode,
    input  logic              cfg_cpol,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              tmr_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_full,
    output logic              wr_collide,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_oe,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              ss_n_i
);
    import spi_port_pkg::*;

    localparam int PIN_SCK = 0;
    localparam int PIN_SS  = 1;

    role_e      role;
    logic [1:0] pin_sync, pin_prev;
    logic       is_master, is_slave, ss_ok;
    logic       s_lead, s_trail, tick, phase, busy;

    assign role      = role_of(cfg_mode);
    assign is_master = (role == ROLE_MASTER);
    assign is_slave  = (role == ROLE_SLAVE);

    spi_pin_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b10)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    ({ss_n_i, sck_i}),
        .synced (pin_sync),
        .prev   (pin_prev)
    );

    assign s_lead  = (pin_sync[PIN_SCK] != cfg_cpol) && (pin_prev[PIN_SCK] == cfg_cpol);
    assign s_trail = (pin_sync[PIN_SCK] == cfg_cpol) && (pin_prev[PIN_SCK] != cfg_cpol);
    assign ss_ok   = (cfg_mode == MODE_S_FREE) || !pin_sync[PIN_SS];

    spi_baud_gen #(
        .DIV_W (DIV_W)
    ) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (cfg_en && is_master && busy),
        .mode     (cfg_mode),
        .div      (cfg_div),
        .tmr_tick (tmr_tick),
        .tick     (tick)
    );

    spi_shift_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg_en),
        .role    (role),
        .ss_ok   (ss_ok),
        .tick    (tick),
        .s_lead  (s_lead),
        .s_trail (s_trail),
        .sdi     (sdi_i),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .sdo     (sdo_o),
        .phase_o (phase),
        .busy_o  (busy),
        .rd_data (rd_data),
        .rx_full (rx_full),
        .wr_coll (wr_collide)
    );

    assign sck_o  = cfg_cpol ^ (is_master && phase);
    assign sck_oe = cfg_en && is_master;
    assign sdo_oe = cfg_en && (is_master || (is_slave && ss_ok));

    // R1: one clock of disable leaves the port with no data and no flags.
    assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (!rx_full && !wr_collide && rd_data == '0 && !sdo_o));

    // R2: an idle master holds SCK at the idle level.
    assert_master_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && is_master && !busy) |-> sck_o == cfg_cpol);

endmodule

// File: tb/dual_role_spi_tb.sv
`timescale 1ns/1ps
module dual_role_spi_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_en, cfg_cpol, tmr_tick, wr_en, rd_en;
    logic [3:0] cfg_mode;
    logic [7:0] cfg_div, wr_data, rd_data;
    logic       rx_full, wr_collide, sdi_i, sdo_o, sdo_oe, sck_i, sck_o, sck_oe, ss_n_i;
    logic       sdi_task;

    int   errors = 0;
    int   checks = 0;
    int   cycles = 0;
    bit   mdl_on = 0;
    bit   tmr_run = 0;
    int   tmr_ph = 0;
    logic [7:0] slv_byte;

    // Behavioural model state for the master role.
    bit         m_busy, m_full, m_coll, was_busy;
    int         m_cnt, m_edges, m_half, adv;
    logic [7:0] m_tx, m_sh, m_rx;

    always #2 clk = ~clk;

    dual_role_spi u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
        .cfg_cpol(cfg_cpol), .cfg_div(cfg_div), .tmr_tick(tmr_tick),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .rx_full(rx_full), .wr_collide(wr_collide), .sdi_i(sdi_i), .sdo_o(sdo_o),
        .sdo_oe(sdo_oe), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .ss_n_i(ss_n_i)
    );

    // In master tests, the far end presents bit (edges/2) of its byte, MSB first.
    assign sdi_i = mdl_on ? ((m_edges < 16) ? slv_byte[7 - (m_edges >> 1)] : 1'b0) : sdi_task;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    // External timer tick: one pulse every third clock while enabled.
    always @(negedge clk) begin
        if (tmr_run) begin
            tmr_ph   = (tmr_ph == 2) ? 0 : tmr_ph + 1;
            tmr_tick = (tmr_ph == 0);
        end else begin
            tmr_tick = 1'b0;
        end
    end

    function automatic int half_for(input logic [3:0] md, input logic [7:0] dv);
        case (md)
            4'b0000: return 2;
            4'b0001: return 8;
            4'b0010: return 32;
            4'b1010: return dv + 1;
            default: return 1;
        endcase
    endfunction

    // Reference model for the master role: advances on each clock from the requirements.
    always @(posedge clk) begin
        if (!rst_n || !cfg_en) begin
            m_busy = 0; m_full = 0; m_coll = 0; m_cnt = 0; m_edges = 0;
            m_tx = 0; m_sh = 0; m_rx = 0;
        end else if (mdl_on) begin
            was_busy = m_busy;
            m_half   = half_for(cfg_mode, cfg_div);
            if (rd_en) m_full = 0;
            if (m_busy) begin
                adv = 0;
                if (cfg_mode == 4'b0011) begin
                    adv = tmr_tick ? 1 : 0;
                end else begin
                    m_cnt++;
                    if (m_cnt == m_half) begin
                        m_cnt = 0;
                        adv = 1;
                    end
                end
                if (adv == 1) begin
                    m_edges++;
                    if (m_edges == 16) begin
                        m_busy = 0; m_full = 1; m_sh = slv_byte; m_rx = slv_byte;
                    end
                end
            end
            if (wr_en) begin
                if (was_busy) m_coll = 1;
                else begin
                    m_busy = 1; m_cnt = 0; m_edges = 0; m_tx = wr_data; m_sh = wr_data;
                end
            end
        end
    end

    // Compares the master-side outputs with the model every clock.
    always @(negedge clk) begin
        if (mdl_on && cfg_en && rst_n) begin
            chk(sck_o == (m_busy ? (cfg_cpol ^ m_edges[0]) : cfg_cpol), "R3 sck_o", sck_o,
                m_busy ? (cfg_cpol ^ m_edges[0]) : cfg_cpol);
            chk(sdo_o == (m_busy ? m_tx[7 - (m_edges >> 1)] : m_sh[7]), "R4 sdo_o", sdo_o,
                m_busy ? m_tx[7 - (m_edges >> 1)] : m_sh[7]);
            chk(rx_full == m_full && rd_data == m_rx, "R5 rx_full/rd_data",
                {rx_full, rd_data}, {m_full, m_rx});
            chk(wr_collide == m_coll, "R8 wr_collide", wr_collide, m_coll);
            chk(sck_oe && sdo_oe, "R2 output enables", {sck_oe, sdo_oe}, 2'b11);
        end
    end

    task automatic setup(input logic [3:0] md, input logic cp, input logic [7:0] dv);
        @(negedge clk);
        cfg_en = 0;
        mdl_on = 0;
        @(negedge clk);
        cfg_mode = md; cfg_cpol = cp; cfg_div = dv; sck_i = cp;
        @(negedge clk);
        cfg_en = 1;
    endtask

    task automatic write_byte(input logic [7:0] d);
        wr_en = 1; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic master_xfer(input logic [3:0] md, input logic cp, input logic [7:0] dv,
                               input logic [7:0] tx, input logic [7:0] rx);
        setup(md, cp, dv);
        slv_byte = rx;
        mdl_on   = 1;
        @(negedge clk);
        write_byte(tx);
        while (m_busy) @(negedge clk);
        @(negedge clk);
        chk(rd_data == rx, "R5 master byte received", rd_data, rx);
        chk(rx_full == 1'b1, "R5 full after transfer", rx_full, 1);
    endtask

    // Slave side: sends bits hi..lo of rx on sdi and checks sdo against tx.
    task automatic s_bits(input logic [7:0] tx, input logic [7:0] rx, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) begin
            sdi_task = rx[i];
            chk(sdo_o == tx[i], "R4 slave sdo bit", sdo_o, tx[i]);
            sck_i = ~cfg_cpol;
            repeat (4) @(negedge clk);
            sck_i = cfg_cpol;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        rst_n = 0; cfg_en = 0; cfg_mode = 4'b0000; cfg_cpol = 0; cfg_div = 0;
        tmr_tick = 0; wr_en = 0; wr_data = 0; rd_en = 0; sck_i = 0; ss_n_i = 1;
        sdi_task = 0; slv_byte = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state with the port disabled
        chk(!sck_oe && !sdo_oe, "R1 enables low", {sck_oe, sdo_oe}, 0);
        chk(!rx_full && !wr_collide && rd_data == 0, "R1 flags clear",
            {rx_full, wr_collide, rd_data}, 0);

        // R3 R4 R5: master transfers at each clock source
        master_xfer(4'b0000, 0, 8'd0, 8'hA5, 8'h3C);
        rd_en = 1; @(negedge clk); rd_en = 0;
        chk(rx_full == 0, "R5 read clears full", rx_full, 0);
        master_xfer(4'b0001, 1, 8'd0, 8'h81, 8'h7E);
        master_xfer(4'b0010, 0, 8'd0, 8'h5B, 8'hC6);
        master_xfer(4'b1010, 1, 8'd0, 8'hF0, 8'h0F);
        master_xfer(4'b1010, 0, 8'd4, 8'h69, 8'h96);
        tmr_run = 1;
        master_xfer(4'b0011, 1, 8'd0, 8'h33, 8'hCA);
        tmr_run = 0;

        // R8: collision in master role; transfer continues unchanged
        setup(4'b0000, 0, 8'd0);
        slv_byte = 8'h55; mdl_on = 1;
        @(negedge clk);
        write_byte(8'hE1);
        repeat (10) @(negedge clk);
        write_byte(8'h1E);
        while (m_busy) @(negedge clk);
        @(negedge clk);
        chk(wr_collide == 1, "R8 master collision flag", wr_collide, 1);
        chk(rd_data == 8'h55, "R8 transfer unaffected", rd_data, 8'h55);

        // R10: read strobe on the completing clock
        setup(4'b0000, 0, 8'd0);
        slv_byte = 8'hB2; mdl_on = 1;
        @(negedge clk);
        write_byte(8'h4D);
        repeat (31) @(negedge clk);
        rd_en = 1; @(negedge clk); rd_en = 0;
        @(negedge clk);
        chk(rx_full == 1, "R10 done wins over read", rx_full, 1);
        chk(rd_data == 8'hB2, "R10 byte kept", rd_data, 8'hB2);

        // R1: disable in the middle of a transfer
        setup(4'b0001, 0, 8'd0);
        slv_byte = 8'h99; mdl_on = 1;
        @(negedge clk);
        write_byte(8'h77);
        repeat (20) @(negedge clk);
        write_byte(8'h01);
        mdl_on = 0;
        cfg_en = 0;
        @(negedge clk);
        chk(!sck_oe && !sdo_oe, "R1 enables drop", {sck_oe, sdo_oe}, 0);
        chk(!rx_full && !wr_collide && rd_data == 0 && !sdo_o, "R1 state cleared",
            {rx_full, wr_collide, rd_data, sdo_o}, 0);
        master_xfer(4'b0000, 1, 8'd0, 8'hC3, 8'h18);

        // R6 R7: slave, select ignored, cpol 0
        setup(4'b0101, 0, 8'd0);
        ss_n_i = 1;
        @(negedge clk);
        chk(!sck_oe, "R6 slave does not drive sck", sck_oe, 0);
        chk(sdo_oe, "R7 select ignored in free mode", sdo_oe, 1);
        write_byte(8'h96);
        repeat (4) @(negedge clk);
        s_bits(8'h96, 8'h5A, 7, 0);
        chk(rx_full && rd_data == 8'h5A, "R6 slave byte received", {rx_full, rd_data}, {1'b1, 8'h5A});
        rd_en = 1; @(negedge clk); rd_en = 0;
        chk(!rx_full, "R5 slave read clears", rx_full, 0);

        // R6: slave with cpol 1
        setup(4'b0101, 1, 8'd0);
        repeat (4) @(negedge clk);
        write_byte(8'hC3);
        repeat (4) @(negedge clk);
        s_bits(8'hC3, 8'h24, 7, 0);
        chk(rx_full && rd_data == 8'h24, "R6 slave cpol1 byte", {rx_full, rd_data}, {1'b1, 8'h24});

        // R7: select-controlled slave, aborted byte then a full one
        setup(4'b0100, 0, 8'd0);
        ss_n_i = 1;
        repeat (4) @(negedge clk);
        chk(!sdo_oe, "R7 deselected sdo released", sdo_oe, 0);
        write_byte(8'h11);
        ss_n_i = 0;
        repeat (4) @(negedge clk);
        chk(sdo_oe, "R7 selected sdo driven", sdo_oe, 1);
        s_bits(8'h11, 8'hFF, 7, 5);
        ss_n_i = 1;
        repeat (4) @(negedge clk);
        chk(!sdo_oe && !rx_full, "R7 abort leaves no byte", {sdo_oe, rx_full}, 0);
        write_byte(8'hE7);
        chk(!wr_collide, "R7 write accepted after abort", wr_collide, 0);
        ss_n_i = 0;
        repeat (4) @(negedge clk);
        s_bits(8'hE7, 8'h6B, 7, 0);
        chk(rx_full && rd_data == 8'h6B, "R7 byte after restart", {rx_full, rd_data}, {1'b1, 8'h6B});

        // R8: slave collision leaves the byte in flight alone
        setup(4'b0101, 0, 8'd0);
        repeat (4) @(negedge clk);
        write_byte(8'h0F);
        repeat (4) @(negedge clk);
        s_bits(8'h0F, 8'hA1, 7, 5);
        write_byte(8'hFF);
        chk(wr_collide, "R8 slave collision flag", wr_collide, 1);
        s_bits(8'h0F, 8'hA1, 4, 0);
        chk(rd_data == 8'hA1 && rx_full, "R8 slave byte intact", rd_data, 8'hA1);

        // R9: unassigned mode drives nothing and starts nothing
        setup(4'b1111, 0, 8'd0);
        @(negedge clk);
        write_byte(8'hFF);
        repeat (40) @(negedge clk);
        chk(!sck_oe && !sdo_oe, "R9 no pins driven", {sck_oe, sdo_oe}, 0);
        chk(!rx_full && !wr_collide && sck_o == 0, "R9 no transfer",
            {rx_full, wr_collide, sck_o}, 0);

        finish_run();
    end

endmodule